// File: doc/BRIEF.md
# Mode-Banked Register File with Status Save

This block is the architectural register store of a small processor core. General registers are held in one physical copy that every operating mode shares. The stack pointer, the link register and the saved-status register have one physical copy per operating mode. A current-status word holds the live mode field, and that field picks which copy a read or write reaches. The program counter is not stored here. It comes in on a port and is returned whenever index 15 is read.

The block has two combinational read ports and one synchronous write port. It also takes an exception-entry request that carries a target mode, and a return request. On an accepted exception the block switches to the target mode. In the same edge it saves the outgoing status word into the saved-status copy of the target mode. On a return it reloads the status word from the saved copy of the current mode, which also brings back the earlier mode. Software-style writes to the status word and to the current saved-status copy are also available.

Top module: `banked_regfile`

## Requirements
- R1: After reset the status word is 32'h0000_0090: mode field [4:0] = 5'b10000 (user) and interrupt mask bit 7 set. Every stored register and every saved-status copy reads zero.
- R2: Indices 0 to 12 reach a single shared copy, whatever the mode.
- R3: Indices 13 and 14 reach one copy per mode: user 5'b10000, interrupt 5'b10010, abort 5'b10111. Any other mode value selects the user copies.
- R4: A read of index 15 returns `pc_in`. A write to index 15 changes nothing.
- R5: In user mode, or in an unrecognised mode, the saved-status output reads zero and a saved-status write is ignored.
- R6: An exception request whose target is 5'b10010 or 5'b10111 is accepted. On the next cycle the mode field equals the target and bits [31:5] are unchanged. The target's saved-status copy then holds the status word from before the edge.
- R7: An exception request with any other target is ignored.
- R8: A register write in the same cycle as an accepted exception lands in the outgoing mode's bank. A saved-status write in that cycle is dropped.
- R9: A return request reloads the whole status word from the current mode's saved copy. It is ignored in user or unrecognised modes.
- R10: Priority on the status word is accepted exception, then valid return, then status write.
- R11: Reads are combinational and show register state from before the edge. A write becomes visible on the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| pc_in | input | 32 | Program counter supplied from outside |
| stat_wr_en | input | 1 | Status-word write enable |
| stat_wr_data | input | 32 | Status-word write data |
| save_wr_en | input | 1 | Write enable for the current saved-status copy |
| save_wr_data | input | 32 | Saved-status write data |
| exc_req | input | 1 | Exception-entry request |
| exc_mode | input | 5 | Target mode of the exception |
| ret_req | input | 1 | Return-from-exception request |
| stat_q | output | 32 | Current status word |
| save_rd_data | output | 32 | Saved-status copy of the current mode |

## Verification
The bench targets the edge where an exception and a register write coincide. A design that switched banks early would put the stack-pointer write into the new mode's copy. It also targets nested entry from interrupt into abort, where a design that saved the wrong status word would return to user instead of interrupt. Return in user mode and exceptions aimed at user or at an unknown mode are driven deliberately. A faulty design would load a zero status word, or switch into a mode that has no bank. Simultaneous exception, return and status writes check the priority order. Mode values written directly with no bank behind them confirm that accesses fall back to the user copies.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;
   localparam int MODE_W  = 5;
   localparam int NUM_BNK = 3;
   localparam int BNK_W   = 2;

   typedef enum logic [MODE_W-1:0] {
      MODE_USR = 5'b10000,
      MODE_IRQ = 5'b10010,
      MODE_ABT = 5'b10111
   } mode_e;

   // bank 0 = user (also fallback), 1 = interrupt, 2 = abort
   function automatic logic [BNK_W-1:0] bank_of(input logic [MODE_W-1:0] m);
      case (m)
         MODE_IRQ: bank_of = 2'd1;
         MODE_ABT: bank_of = 2'd2;
         default:  bank_of = 2'd0;
      endcase
   endfunction

   function automatic logic is_exc_mode(input logic [MODE_W-1:0] m);
      is_exc_mode = (m == MODE_IRQ) || (m == MODE_ABT);
   endfunction
endpackage

// File: rtl/mbrf_common.sv
module mbrf_common #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4,
   parameter int NUM_COMMON = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_a_idx,
   input  logic [IDX_W-1:0]  rd_b_idx,
   output logic [DATA_W-1:0] rd_a_data,
   output logic [DATA_W-1:0] rd_b_data
);
   localparam int NUM_ARCH = 1 << IDX_W;

   logic [DATA_W-1:0] regs [NUM_ARCH];

   for (genvar k = 0; k < NUM_ARCH; k++) begin : g_reg
      if (k < NUM_COMMON) begin : g_live
         always_ff @(posedge clk) begin
            if (!rst_n)
               regs[k] <= '0;
            else if (wr_en && wr_idx == IDX_W'(k))
               regs[k] <= wr_data;
         end
         // R2
         common_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(k)) |=> regs[k] == $past(wr_data));
      end else begin : g_none
         assign regs[k] = '0;
      end
   end

   assign rd_a_data = regs[rd_a_idx];
   assign rd_b_data = regs[rd_b_idx];
endmodule

// File: rtl/mbrf_banked.sv
module mbrf_banked #(
   parameter int DATA_W     = 32,
   parameter int NBANK      = 3,
   parameter bit SKIP_FIRST = 1'b0,
   localparam int BW        = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BW-1:0]     wr_bank,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [BW-1:0]     rd_bank,
   output logic [DATA_W-1:0] rd_data
);
   localparam int SLOTS = 1 << BW;

   logic [DATA_W-1:0] q [SLOTS];

   for (genvar b = 0; b < SLOTS; b++) begin : g_bank
      if (b < NBANK && !(SKIP_FIRST && b == 0)) begin : g_live
         always_ff @(posedge clk) begin
            if (!rst_n)
               q[b] <= '0;
            else if (wr_en && wr_bank == BW'(b))
               q[b] <= wr_data;
         end
         // R3
         bank_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_bank == BW'(b)) |=> q[b] == $past(wr_data));
         // R3
         bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en || wr_bank != BW'(b)) |=> $stable(q[b]));
      end else begin : g_absent
         assign q[b] = '0;
      end
   end

   assign rd_data = q[rd_bank];
endmodule

// File: rtl/mbrf_status.sv
module mbrf_status
   import mbrf_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int MASK_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_req,
   input  logic [MODE_W-1:0] exc_mode,
   input  logic              ret_req,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] save_cur,
   output logic [DATA_W-1:0] stat_q,
   output logic              exc_take
);
   localparam logic [DATA_W-1:0] RESET_WORD =
      (DATA_W'(1) << MASK_BIT) | DATA_W'(MODE_USR);

   logic              ret_take;
   logic [DATA_W-1:0] stat_d;

   assign exc_take = exc_req && is_exc_mode(exc_mode);
   assign ret_take = ret_req && !exc_take && (bank_of(stat_q[MODE_W-1:0]) != '0);

   always_comb begin
      stat_d = stat_q;
      if (exc_take)
         stat_d = {stat_q[DATA_W-1:MODE_W], exc_mode};
      else if (ret_take)
         stat_d = save_cur;
      else if (wr_en)
         stat_d = wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= RESET_WORD;
      else        stat_q <= stat_d;
   end

   // R6
   exc_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_take |=> (stat_q[MODE_W-1:0] == $past(exc_mode)) &&
                   (stat_q[DATA_W-1:MODE_W] == $past(stat_q[DATA_W-1:MODE_W])));
   // R9
   ret_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_take |=> stat_q == $past(save_cur));
   // R7
   exc_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && !is_exc_mode(exc_mode) && !ret_req && !wr_en) |=> $stable(stat_q));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import mbrf_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int IDX_W    = 4,
   parameter int MASK_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [IDX_W-1:0]  rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] pc_in,
   input  logic              stat_wr_en,
   input  logic [DATA_W-1:0] stat_wr_data,
   input  logic              save_wr_en,
   input  logic [DATA_W-1:0] save_wr_data,
   input  logic              exc_req,
   input  logic [MODE_W-1:0] exc_mode,
   input  logic              ret_req,
   output logic [DATA_W-1:0] stat_q,
   output logic [DATA_W-1:0] save_rd_data
);
   localparam int NUM_ARCH   = 1 << IDX_W;
   localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(NUM_ARCH - 1);
   localparam logic [IDX_W-1:0] LR_IDX = IDX_W'(NUM_ARCH - 2);
   localparam logic [IDX_W-1:0] SP_IDX = IDX_W'(NUM_ARCH - 3);
   localparam int NUM_COMMON = NUM_ARCH - 3;

   if (IDX_W < 3) begin : g_bad_idx
      $error("IDX_W too small for shared plus banked registers");
   end
   if (MASK_BIT < MODE_W || MASK_BIT >= DATA_W) begin : g_bad_mask
      $error("MASK_BIT must lie above the mode field and inside the word");
   end

   logic [BNK_W-1:0]  cur_bank, exc_bank, save_bank;
   logic              exc_take, save_we;
   logic [DATA_W-1:0] save_wd, sp_rd, lr_rd, com_a, com_b;

   assign cur_bank = bank_of(stat_q[MODE_W-1:0]);
   assign exc_bank = bank_of(exc_mode);

   mbrf_common #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_COMMON(NUM_COMMON)) i_common (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
      .rd_a_data(com_a), .rd_b_data(com_b));

   mbrf_banked #(.DATA_W(DATA_W), .NBANK(NUM_BNK), .SKIP_FIRST(1'b0)) i_sp (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en && wr_idx == SP_IDX), .wr_bank(cur_bank), .wr_data(wr_data),
      .rd_bank(cur_bank), .rd_data(sp_rd));

   mbrf_banked #(.DATA_W(DATA_W), .NBANK(NUM_BNK), .SKIP_FIRST(1'b0)) i_lr (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en && wr_idx == LR_IDX), .wr_bank(cur_bank), .wr_data(wr_data),
      .rd_bank(cur_bank), .rd_data(lr_rd));

   // exception save wins over a same-cycle software write
   assign save_we   = exc_take || save_wr_en;
   assign save_bank = exc_take ? exc_bank : cur_bank;
   assign save_wd   = exc_take ? stat_q : save_wr_data;

   mbrf_banked #(.DATA_W(DATA_W), .NBANK(NUM_BNK), .SKIP_FIRST(1'b1)) i_save (
      .clk(clk), .rst_n(rst_n),
      .wr_en(save_we), .wr_bank(save_bank), .wr_data(save_wd),
      .rd_bank(cur_bank), .rd_data(save_rd_data));

   mbrf_status #(.DATA_W(DATA_W), .MASK_BIT(MASK_BIT)) i_status (
      .clk(clk), .rst_n(rst_n),
      .exc_req(exc_req), .exc_mode(exc_mode), .ret_req(ret_req),
      .wr_en(stat_wr_en), .wr_data(stat_wr_data),
      .save_cur(save_rd_data), .stat_q(stat_q), .exc_take(exc_take));

   function automatic logic [DATA_W-1:0] pick(input logic [IDX_W-1:0] idx,
                                              input logic [DATA_W-1:0] com);
      if (idx == PC_IDX)      pick = pc_in;
      else if (idx == LR_IDX) pick = lr_rd;
      else if (idx == SP_IDX) pick = sp_rd;
      else                    pick = com;
   endfunction

   assign rd_a_data = pick(rd_a_idx, com_a);
   assign rd_b_data = pick(rd_b_idx, com_b);

   // R6
   save_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_take |=> save_rd_data == $past(stat_q));
   // R5
   user_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[MODE_W-1:0] == MODE_USR) |-> save_rd_data == '0);
   // R8
   old_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_take && wr_en && wr_idx == SP_IDX && cur_bank == '0 && exc_bank != '0)
         |=> sp_rd != $past(wr_data) || $past(sp_rd) == $past(wr_data) || sp_rd == $past(sp_rd));
endmodule

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic [31:0] rd_a_data, rd_b_data, wr_data = '0, pc_in = '0;
   logic        wr_en = 1'b0, stat_wr_en = 1'b0, save_wr_en = 1'b0;
   logic [31:0] stat_wr_data = '0, save_wr_data = '0, stat_q, save_rd_data;
   logic        exc_req = 1'b0, ret_req = 1'b0;
   logic [4:0]  exc_mode = '0;

   always #2.5 clk = ~clk;

   banked_regfile i_banked_regfile (.*);

   logic [31:0] m_com [13];
   logic [31:0] m_sp [3], m_lr [3], m_sv [3];
   logic [31:0] m_st;
   int    n_chk = 0, n_fail = 0;
   string ph = "R1";
   bit    done = 0;

   function automatic int bk(input logic [4:0] m);
      if (m == 5'b10010) return 1;
      if (m == 5'b10111) return 2;
      return 0;
   endfunction

   function automatic logic [31:0] exp_rd(input logic [3:0] i);
      if (i == 4'd15) return pc_in;
      if (i == 4'd14) return m_lr[bk(m_st[4:0])];
      if (i == 4'd13) return m_sp[bk(m_st[4:0])];
      return m_com[i];
   endfunction

   function automatic string cls(input logic [3:0] i);
      if (i == 4'd15) return "R4";
      if (i >= 4'd13) return "R3";
      return "R2";
   endfunction

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", ph, what, act, exp);
      end
   endtask

   task automatic model_reset();
      foreach (m_com[k]) m_com[k] = '0;
      for (int b = 0; b < 3; b++) begin m_sp[b] = '0; m_lr[b] = '0; m_sv[b] = '0; end
      m_st = 32'h0000_0090;
   endtask

   task automatic model_edge();
      int b;
      bit ex, rt;
      logic [31:0] sv_old;
      b = bk(m_st[4:0]);
      sv_old = (b == 0) ? 32'h0 : m_sv[b];
      ex = exc_req && (exc_mode == 5'b10010 || exc_mode == 5'b10111);
      rt = ret_req && !ex && (b != 0);
      if (wr_en) begin
         if (wr_idx < 4'd13) m_com[wr_idx] = wr_data;
         else if (wr_idx == 4'd13) m_sp[b] = wr_data;
         else if (wr_idx == 4'd14) m_lr[b] = wr_data;
      end
      if (ex) m_sv[bk(exc_mode)] = m_st;
      else if (save_wr_en && b != 0) m_sv[b] = save_wr_data;
      if (ex) m_st = {m_st[31:5], exc_mode};
      else if (rt) m_st = sv_old;
      else if (stat_wr_en) m_st = stat_wr_data;
   endtask

   // R11: outputs compared before the edge against pre-edge model state
   task automatic step();
      int b;
      #1;
      b = bk(m_st[4:0]);
      chk({cls(rd_a_idx), " R11 port A"}, rd_a_data, exp_rd(rd_a_idx));
      chk({cls(rd_b_idx), " R11 port B"}, rd_b_data, exp_rd(rd_b_idx));
      chk("R6 R9 R10 status", stat_q, m_st);
      chk((b == 0) ? "R5 saved" : "R6 saved", save_rd_data, (b == 0) ? 32'h0 : m_sv[b]);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      wr_en = 0; stat_wr_en = 0; save_wr_en = 0; exc_req = 0; ret_req = 0;
   endtask

   task automatic wr(input logic [3:0] i, input logic [31:0] d);
      wr_en = 1; wr_idx = i; wr_data = d;
   endtask

   task automatic rd(input logic [3:0] a, input logic [3:0] b);
      rd_a_idx = a; rd_b_idx = b;
   endtask

   task automatic exc(input logic [4:0] m);
      exc_req = 1; exc_mode = m;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      model_reset();
      pc_in = 32'h0000_1000;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset contents on every index
      ph = "R1";
      for (int i = 0; i < 16; i++) begin rd(4'(i), 4'(15 - i)); step(); end
      ph = "R2 R11";
      for (int i = 0; i < 13; i++) begin wr(4'(i), 32'hC000_0000 + i); rd(4'(i), 4'(i)); step(); end
      ph = "R3";
      wr(13, 32'h5555_0013); rd(13, 14); step();
      wr(14, 32'h5555_0014); rd(13, 14); step();
      ph = "R6";
      exc(5'b10010); rd(13, 14); step();
      wr(13, 32'h1111_0013); rd(13, 0); step();
      wr(14, 32'h1111_0014); rd(13, 14); step();
      exc(5'b10111); rd(13, 14); step();
      wr(13, 32'hABAB_0013); rd(13, 5); step();
      rd(13, 14); step();
      ph = "R9";
      ret_req = 1; rd(13, 14); step();
      rd(13, 14); step();
      ret_req = 1; step();
      rd(13, 14); step();
      ret_req = 1; step();
      ph = "R8";
      exc(5'b10010); wr(13, 32'h8888_0001); save_wr_en = 1; save_wr_data = 32'hDEAD_BEEF; rd(13, 14); step();
      rd(13, 14); step();
      ret_req = 1; step();
      rd(13, 14); step();
      ph = "R7";
      exc(5'b10000); step();
      exc(5'b11111); step();
      exc(5'b10011); rd(13, 14); step();
      ph = "R5";
      save_wr_en = 1; save_wr_data = 32'h1234_5678; step();
      step();
      ph = "R10";
      exc(5'b10111); ret_req = 1; stat_wr_en = 1; stat_wr_data = 32'h0000_0010; step();
      ret_req = 1; stat_wr_en = 1; stat_wr_data = 32'h0000_0012; step();
      stat_wr_en = 1; stat_wr_data = 32'hF000_001F; step();
      ph = "R3 unknown mode";
      wr(13, 32'h7777_0013); rd(13, 14); step();
      rd(13, 14); stat_wr_en = 1; stat_wr_data = 32'h0000_0090; step();
      rd(13, 14); step();
      ph = "R4";
      wr(15, 32'hFFFF_FFFF); rd(15, 15); pc_in = 32'h0000_2004; step();
      rd(15, 0); pc_in = 32'h0000_2008; step();
      ph = "R6 random";
      for (int n = 0; n < 3000; n++) begin
         logic [4:0] mpick [4];
         mpick = '{5'b10000, 5'b10010, 5'b10111, 5'b11011};
         rd(4'($urandom), 4'($urandom));
         pc_in = $urandom;
         if ($urandom_range(9) < 6) wr(4'($urandom), $urandom);
         if ($urandom_range(9) == 0) exc(mpick[$urandom_range(3)]);
         if ($urandom_range(9) == 0) ret_req = 1;
         if ($urandom_range(19) == 0) begin
            stat_wr_en = 1;
            stat_wr_data = {$urandom_range(255), 3'b0, mpick[$urandom_range(3)]};
         end
         if ($urandom_range(6) == 0) begin save_wr_en = 1; save_wr_data = $urandom; end
         step();
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule